// File: doc/BRIEF.md
# Programmable Bus Ready Generator

This block drives the active-high ready line that ends each processor bus cycle. The bus cycle has two phases. An address strobe phase captures the cycle qualifiers: memory or I/O, two extended-address bits, and flags for self-test and internal I/O. A data strobe phase follows, with the data strobe active low. When the data strobe falls, a counter is loaded with a wait count. Ready rises once that count has run out and stays high until the data strobe returns high.

Memory cycles take their wait count from one of four 3-bit fields. When mapping is enabled, the two extended-address bits from a memory management unit choose the field. I/O cycles use a single 3-bit field of their own. Self-test cycles and cycles that target the block's own internal I/O registers get ready with zero wait states. Two external ready inputs can each hold ready low: one is active high and the other is active low. Neither of them stops the wait counter.

Top module: `bus_ready_gen`

## Requirements
- R1: While `rst` is sampled high, `ready` is low at the next edge. After reset, no wait count runs until the data strobe has been sampled high and then low again.
- R2: `ready` is low after every edge at which `dstrb_n` is sampled high.
- R3: Let E0 be the first edge at which `dstrb_n` is sampled low, after an edge at which it was sampled high. Then `ready` is first high after edge E0+W, where W is the selected wait count (0 to 7).
- R4: For a memory cycle with `map_en`=1, W is the field of `mem_wait_cfg` at bits [3i+2:3i], with i the latched `ext_addr`.
- R5: For a memory cycle with `map_en`=0, W is field 0 (`mem_wait_cfg[2:0]`), whatever the value of `ext_addr`.
- R6: For an I/O cycle (`bus_is_mem`=0), W is `io_wait_cfg`.
- R7: If `selftest_on` or `int_io_hit` is latched high, W is 0, whatever the cycle type and the configuration.
- R8: If `ext_rdy` is sampled low at an edge, `ready` is low after that edge. The wait count keeps running, so `ready` rises at the first edge with `ext_rdy` high once W has elapsed.
- R9: If `ext_rdy_n` is sampled high at an edge, `ready` is low after that edge. The count runs on, in the same way as in R8.
- R10: Qualifiers are latched at each edge where `addr_strobe` is high. Changes to them later in the cycle have no effect on W.
- R11: Once `ready` is high, it stays high while `dstrb_n` stays low and both external ready inputs permit it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_strobe | input | 1 | Address phase strobe, active high; latches the qualifiers |
| dstrb_n | input | 1 | Data strobe, active low |
| bus_is_mem | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| ext_addr | input | 2 | Extended-address bits that select the memory wait field |
| map_en | input | 1 | 1: `ext_addr` selects the memory field; 0: field 0 is used |
| selftest_on | input | 1 | Current cycle belongs to the built-in self-test |
| int_io_hit | input | 1 | Current cycle targets the block's internal I/O registers |
| ext_rdy | input | 1 | External ready, active high; low forces `ready` low |
| ext_rdy_n | input | 1 | External ready, active low; high forces `ready` low |
| mem_wait_cfg | input | 12 | Four 3-bit memory wait counts; field i at [3i+2:3i] |
| io_wait_cfg | input | 3 | I/O wait count |
| ready | output | 1 | Bus-cycle termination ready, registered |

## Verification
Memory cycles are run through all four extended-address values. Each field holds a distinct count (2, 5, 0, 7), so a wrong index, or a count that is off by one, shows up as ready rising on the wrong edge. Further cycles set mapping off with a non-zero index, run an I/O cycle, and run self-test and internal-I/O cycles with long configured waits. These separate the rules that choose the count from one another. Each external ready input is held inactive across the point where the count expires. This shows that the gating acts on its own and that counting goes on beneath it. A cycle whose qualifiers change after the address strobe, and a reset during a counting cycle, test the latching and the clearing.

// File: rtl/bus_ready_pkg.sv
package bus_ready_pkg;
  typedef enum logic [1:0] {
    CYC_MEM  = 2'd0,
    CYC_IO   = 2'd1,
    CYC_AUTO = 2'd2
  } cyc_kind_t;
endpackage

// File: rtl/rdy_cycle_latch.sv
module rdy_cycle_latch
  import bus_ready_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             addr_strobe,
  input  logic             bus_is_mem,
  input  logic [SEL_W-1:0] ext_addr,
  input  logic             map_en,
  input  logic             selftest_on,
  input  logic             int_io_hit,
  output cyc_kind_t        kind_q,
  output logic [SEL_W-1:0] sel_q
);
  cyc_kind_t kind_d;

  always_comb begin
    if (selftest_on || int_io_hit) kind_d = CYC_AUTO;
    else if (bus_is_mem)           kind_d = CYC_MEM;
    else                           kind_d = CYC_IO;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= CYC_IO;
      sel_q  <= '0;
    end else if (addr_strobe) begin
      kind_q <= kind_d;
      sel_q  <= map_en ? ext_addr : '0;
    end
  end
endmodule

// File: rtl/rdy_wait_select.sv
module rdy_wait_select
  import bus_ready_pkg::*;
#(
  parameter int WAIT_W     = 3,
  parameter int MEM_FIELDS = 4,
  localparam int SEL_W     = $clog2(MEM_FIELDS)
) (
  input  cyc_kind_t                  kind,
  input  logic [SEL_W-1:0]           sel,
  input  logic [MEM_FIELDS*WAIT_W-1:0] mem_wait_cfg,
  input  logic [WAIT_W-1:0]          io_wait_cfg,
  output logic [WAIT_W-1:0]          wait_cnt
);
  logic [WAIT_W-1:0] mem_field [MEM_FIELDS];

  for (genvar i = 0; i < MEM_FIELDS; i++) begin : g_unpack
    assign mem_field[i] = mem_wait_cfg[i*WAIT_W +: WAIT_W];
  end

  always_comb begin
    unique case (kind)
      CYC_MEM:  wait_cnt = mem_field[sel];
      CYC_IO:   wait_cnt = io_wait_cfg;
      default:  wait_cnt = '0;
    endcase
  end
endmodule

// File: rtl/rdy_wait_ctr.sv
module rdy_wait_ctr #(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dstrb_n,
  input  logic [WAIT_W-1:0] wait_cnt,
  output logic              done_nxt
);
  logic              prev_hi_q;
  logic              active_q, active_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              start;

  assign start = prev_hi_q && !dstrb_n;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (dstrb_n) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else if (start) begin
      active_d = 1'b1;
      cnt_d    = wait_cnt;
    end else if (active_q && cnt_q != '0) begin
      cnt_d    = cnt_q - 1'b1;
    end
  end

  assign done_nxt = active_d && (cnt_d == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_hi_q <= 1'b0;
      active_q  <= 1'b0;
      cnt_q     <= '0;
    end else begin
      prev_hi_q <= dstrb_n;
      active_q  <= active_d;
      cnt_q     <= cnt_d;
    end
  end
endmodule

// File: rtl/bus_ready_gen.sv
module bus_ready_gen
  import bus_ready_pkg::*;
#(
  parameter int WAIT_W     = 3,
  parameter int MEM_FIELDS = 4,
  localparam int SEL_W     = $clog2(MEM_FIELDS),
  localparam int CFG_W     = MEM_FIELDS * WAIT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             addr_strobe,
  input  logic             dstrb_n,
  input  logic             bus_is_mem,
  input  logic [SEL_W-1:0] ext_addr,
  input  logic             map_en,
  input  logic             selftest_on,
  input  logic             int_io_hit,
  input  logic             ext_rdy,
  input  logic             ext_rdy_n,
  input  logic [CFG_W-1:0] mem_wait_cfg,
  input  logic [WAIT_W-1:0] io_wait_cfg,
  output logic             ready
);
  cyc_kind_t         kind_q;
  logic [SEL_W-1:0]  sel_q;
  logic [WAIT_W-1:0] wait_cnt;
  logic              done_nxt;
  logic              ready_q;

  rdy_cycle_latch #(.SEL_W(SEL_W)) u_latch (
    .clk        (clk),
    .rst        (rst),
    .addr_strobe(addr_strobe),
    .bus_is_mem (bus_is_mem),
    .ext_addr   (ext_addr),
    .map_en     (map_en),
    .selftest_on(selftest_on),
    .int_io_hit (int_io_hit),
    .kind_q     (kind_q),
    .sel_q      (sel_q)
  );

  rdy_wait_select #(.WAIT_W(WAIT_W), .MEM_FIELDS(MEM_FIELDS)) u_select (
    .kind        (kind_q),
    .sel         (sel_q),
    .mem_wait_cfg(mem_wait_cfg),
    .io_wait_cfg (io_wait_cfg),
    .wait_cnt    (wait_cnt)
  );

  rdy_wait_ctr #(.WAIT_W(WAIT_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .dstrb_n (dstrb_n),
    .wait_cnt(wait_cnt),
    .done_nxt(done_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= done_nxt && ext_rdy && !ext_rdy_n;
  end

  assign ready = ready_q;
endmodule

// File: rtl/bus_ready_gen_chk.sv
module bus_ready_gen_chk (
  input logic clk,
  input logic rst,
  input logic dstrb_n,
  input logic ext_rdy,
  input logic ext_rdy_n,
  input logic ready
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !ready); // R1
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    dstrb_n |=> !ready); // R2
  AST_EXT_HI_GATE: assert property (@(posedge clk) disable iff (rst)
    !ext_rdy |=> !ready); // R8
  AST_EXT_LO_GATE: assert property (@(posedge clk) disable iff (rst)
    ext_rdy_n |=> !ready); // R9
  AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (ready && !dstrb_n) |=> (ready || dstrb_n || !ext_rdy || ext_rdy_n)); // R11
endmodule

bind bus_ready_gen bus_ready_gen_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .dstrb_n  (dstrb_n),
  .ext_rdy  (ext_rdy),
  .ext_rdy_n(ext_rdy_n),
  .ready    (ready)
);

// File: tb/tb_bus_ready_gen.sv
module tb_bus_ready_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addr_strobe = 1'b0;
  logic        dstrb_n = 1'b1;
  logic        bus_is_mem = 1'b0;
  logic [1:0]  ext_addr = 2'd0;
  logic        map_en = 1'b1;
  logic        selftest_on = 1'b0;
  logic        int_io_hit = 1'b0;
  logic        ext_rdy = 1'b1;
  logic        ext_rdy_n = 1'b0;
  logic [11:0] mem_wait_cfg = {3'd7, 3'd0, 3'd5, 3'd2};
  logic [2:0]  io_wait_cfg = 3'd3;
  logic        ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bus_ready_gen dut (
    .clk(clk), .rst(rst), .addr_strobe(addr_strobe), .dstrb_n(dstrb_n),
    .bus_is_mem(bus_is_mem), .ext_addr(ext_addr), .map_en(map_en),
    .selftest_on(selftest_on), .int_io_hit(int_io_hit), .ext_rdy(ext_rdy),
    .ext_rdy_n(ext_rdy_n), .mem_wait_cfg(mem_wait_cfg),
    .io_wait_cfg(io_wait_cfg), .ready(ready)
  );

  task automatic check(input logic exp, input string req, input string what);
    checks++;
    if (ready !== exp) begin
      fails++;
      $display("FAIL %s %s: ready=%b expected=%b", req, what, ready, exp);
    end
  endtask

  // address phase, optional scrambling of qualifiers afterwards (R10)
  task automatic addr_phase(input logic mem, input logic [1:0] sel,
                            input logic st, input logic ih, input bit scramble);
    @(negedge clk);
    addr_strobe = 1'b1; bus_is_mem = mem; ext_addr = sel;
    selftest_on = st; int_io_hit = ih;
    @(negedge clk);
    addr_strobe = 1'b0;
    if (scramble) begin
      bus_is_mem = ~mem; ext_addr = ~sel; selftest_on = ~st; int_io_hit = 1'b0;
    end
    @(negedge clk);
  endtask

  // full cycle: ready expected from sample k = exp_w onward, then R2 drop
  task automatic run_cycle(input logic mem, input logic [1:0] sel,
                           input logic st, input logic ih, input bit scramble,
                           input int exp_w, input string req);
    addr_phase(mem, sel, st, ih, scramble);
    dstrb_n = 1'b0;
    for (int k = 0; k <= exp_w + 1; k++) begin
      @(negedge clk);
      check(k >= exp_w, req, $sformatf("wait edge %0d", k));
    end
    dstrb_n = 1'b1;
    @(negedge clk);
    check(1'b0, "R2", "strobe released");
    selftest_on = 1'b0; int_io_hit = 1'b0;
  endtask

  task automatic test_reset;
    repeat (3) @(negedge clk);
    check(1'b0, "R1", "during reset");
    rst = 1'b0;
    @(negedge clk);
    check(1'b0, "R1", "after reset idle");
  endtask

  task automatic test_fields;
    map_en = 1'b1;
    run_cycle(1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 2, "R4");
    run_cycle(1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 5, "R4");
    run_cycle(1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 0, "R3");
    run_cycle(1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 7, "R3");
  endtask

  task automatic test_nomap;
    map_en = 1'b0;
    run_cycle(1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 2, "R5");
    map_en = 1'b1;
  endtask

  task automatic test_io;
    run_cycle(1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 3, "R6");
  endtask

  task automatic test_auto;
    run_cycle(1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 0, "R7");
    run_cycle(1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 0, "R7");
  endtask

  task automatic test_latch;
    // latched: memory, field 1 (5 waits); scrambled to I/O, field 2, selftest
    run_cycle(1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 5, "R10");
  endtask

  // which=0 drives ext_rdy low, which=1 drives ext_rdy_n high; field 1 = 5
  task automatic test_ext(input int which, input string req);
    addr_phase(1'b1, 2'd1, 1'b0, 1'b0, 1'b0);
    dstrb_n = 1'b0;
    for (int k = 0; k <= 7; k++) begin
      @(negedge clk);
      check(k >= 2 ? 1'b0 : 1'b0, req, $sformatf("held edge %0d", k));
      if (k == 1) begin
        if (which == 0) ext_rdy = 1'b0; else ext_rdy_n = 1'b1;
      end
    end
    ext_rdy = 1'b1; ext_rdy_n = 1'b0;
    @(negedge clk);
    check(1'b1, req, "released after count expired");
    @(negedge clk);
    check(1'b1, "R11", "held high");
    dstrb_n = 1'b1;
    @(negedge clk);
    check(1'b0, "R2", "strobe released");
  endtask

  task automatic test_reset_mid;
    addr_phase(1'b1, 2'd3, 1'b0, 1'b0, 1'b0);
    dstrb_n = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(1'b0, "R1", "reset mid cycle");
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check(1'b0, "R1", "no restart without new strobe fall");
    dstrb_n = 1'b1;
    @(negedge clk);
    run_cycle(1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 2, "R1");
  endtask

  initial begin
    test_reset;
    test_fields;
    test_nomap;
    test_io;
    test_auto;
    test_latch;
    test_ext(0, "R8");
    test_ext(1, "R9");
    test_reset_mid;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule